// File: doc/BRIEF.md
# Sprite Memory Write Steering Unit

This unit sits between the CPU memory write path and a 512-entry sprite store. A four-bit control register selects whether sprite writing is active, which of two bit planes is written, and how the two legacy display windows (segments A000h and B000h) are mapped onto four banks of 128 sprites. When sprite writing is active, a CPU write that lands in one of the two windows is turned into a sprite RAM write carrying a sprite index, a byte offset inside that sprite's plane, a one-hot plane strobe and the unmodified CPU byte. The unit also raises a bypass flag so that the normal graphics write logic leaves that write alone.

Each 64 KB window is split by the CPU offset: the upper seven offset bits pick one of 128 sprites inside the bank, the lower nine bits give the byte position. The page-select bit picks the odd or even bank of a pair, and the swap bit decides whether the upper pair of banks is reached through the A000h window (and the B000h window is then dead) or through the B000h window. Sprite RAM outputs are registered and appear one clock after the CPU write is presented.

Top module: `sprite_wr_steer`

## Requirements
- R1: After reset the control register reads 0, and spr_we, spr_plane_we and gfx_bypass are all 0.
- R2: A register write stores wdata[3:0] as bit 3 = page select, bit 2 = plane select, bit 1 = swap, bit 0 = enable; reg_rdata returns these in the same positions with bits 7 to 4 reading 0 whatever was written there.
- R3: With enable = 0, a CPU write to any segment produces spr_we = 0 and gfx_bypass = 0 on the following clock.
- R4: With enable = 1, a CPU write whose segment is A000h or B000h sets gfx_bypass to 1 on the following clock, and every sprite write (spr_we = 1) is accompanied by gfx_bypass = 1.
- R5: The plane strobe is one-hot when spr_we = 1 and zero otherwise: plane select 0 gives spr_plane_we = 2'b01, plane select 1 gives 2'b10.
- R6: With swap = 0, a write at segment A000h reaches sprite 0 + offset[15:9] when page select is 0 and sprite 128 + offset[15:9] when page select is 1.
- R7: With swap = 1, a write at segment A000h reaches sprite 256 + offset[15:9] when page select is 0 and sprite 384 + offset[15:9] when page select is 1.
- R8: With swap = 0, a write at segment B000h reaches sprite 256 + offset[15:9] when page select is 0 and sprite 384 + offset[15:9] when page select is 1.
- R9: With swap = 1, a write at segment B000h produces spr_we = 0 (gfx_bypass still follows R4).
- R10: On a sprite write, spr_ofs equals CPU offset[8:0] and spr_data equals the CPU byte unchanged.
- R11: A CPU write whose segment is neither A000h nor B000h produces spr_we = 0 and gfx_bypass = 0.
- R12: A CPU write presented in the same cycle as a register write is steered by the old register value; the new value applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| mem_we | input | 1 | CPU memory write strobe |
| mem_seg | input | 16 | CPU memory segment value |
| mem_addr | input | 16 | CPU offset within the segment |
| mem_data | input | 8 | CPU write byte |
| spr_we | output | 1 | Sprite RAM write strobe |
| spr_idx | output | 9 | Sprite index 0 to 511 |
| spr_ofs | output | 9 | Byte offset inside the sprite plane |
| spr_plane_we | output | 2 | One-hot plane strobe |
| spr_data | output | 8 | Byte written to the sprite RAM |
| gfx_bypass | output | 1 | Normal graphics write logic must skip this write |

## Verification
The assertions take for granted that reg_we, reg_wdata, mem_we and mem_seg carry known values at every rising edge once the internal reset has been released, and that a register write and a memory write sampled at the same edge see the register value from before that edge. The stimulus changes every input only on the falling clock edge, holds it for a full cycle, keeps all strobes low through reset and for several cycles after its release, and only then starts writing. Each memory write is followed by an idle cycle so that every registered output can be related to exactly one CPU write.

// File: rtl/spr_steer_pkg.sv
package spr_steer_pkg;

  // Control bits, MSB first: page select, plane select, swap, enable.
  typedef struct packed {
    logic page;
    logic plane;
    logic swap;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LO   = 2'd1,
    WIN_HI   = 2'd2
  } win_e;

endpackage

// File: rtl/spr_ctrl_reg.sv
module spr_ctrl_reg
  import spr_steer_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rdata
);

  localparam int unsigned PAD_W = REG_W - CTRL_W;

  ctrl_t ctrl_d;
  ctrl_t ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign rdata = {{PAD_W{1'b0}}, ctrl_q};

  // R2: the written low bits are what the register holds one edge later
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));

  // R2: without a write the register keeps its value
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl_q));

endmodule

// File: rtl/spr_addr_map.sv
module spr_addr_map
  import spr_steer_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 9,
  parameter logic [SEG_W-1:0] SEG_LO_VAL = 16'hA000,
  parameter logic [SEG_W-1:0] SEG_HI_VAL = 16'hB000
) (
  input  ctrl_t                        ctrl,
  input  logic [SEG_W-1:0]             seg,
  input  logic [ADDR_W-1:0]            addr,
  output logic                         in_win,
  output logic                         hit,
  output logic [ADDR_W-OFS_W+1:0]      idx,
  output logic [OFS_W-1:0]             ofs
);

  localparam int unsigned SLOT_W = ADDR_W - OFS_W;

  win_e       win;
  logic [1:0] bank;

  always_comb begin
    win = WIN_NONE;
    if (seg == SEG_LO_VAL) begin
      win = WIN_LO;
    end else if (seg == SEG_HI_VAL) begin
      win = WIN_HI;
    end
  end

  always_comb begin
    bank = 2'b00;
    hit  = 1'b0;
    unique case (win)
      WIN_LO: begin
        bank = {ctrl.swap, ctrl.page};
        hit  = 1'b1;
      end
      WIN_HI: begin
        bank = {1'b1, ctrl.page};
        hit  = !ctrl.swap;
      end
      default: begin
        bank = 2'b00;
        hit  = 1'b0;
      end
    endcase
  end

  assign in_win = (win != WIN_NONE);
  assign idx    = {bank, addr[ADDR_W-1:OFS_W]};
  assign ofs    = addr[OFS_W-1:0];

  // R9: the high window never hits while the upper banks are swapped low
  always_comb begin
    if (win == WIN_HI && ctrl.swap) begin
      a_hi_dead_r9: assert (!hit);
    end
  end

  // R6, R7: the low window always hits and lands in the lower half unless swapped
  always_comb begin
    if (win == WIN_LO) begin
      a_lo_half_r6: assert (hit && (idx[SLOT_W+1] == ctrl.swap));
    end
  end

endmodule

// File: rtl/spr_out_stage.sv
module spr_out_stage #(
  parameter int unsigned PLANES = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFS_W  = 9,
  localparam int unsigned PSEL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              byp,
  input  logic [PSEL_W-1:0] plane_sel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] data,
  output logic              we_o,
  output logic [PLANES-1:0] strobe_o,
  output logic              byp_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [DATA_W-1:0] data_o
);

  logic [PLANES-1:0] strobe_d;
  logic [PLANES-1:0] strobe_q;
  logic              we_q;
  logic              byp_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;

  for (genvar g = 0; g < PLANES; g++) begin : g_plane
    always_comb begin
      strobe_d[g] = go && (plane_sel == PSEL_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b0;
      byp_q    <= 1'b0;
      strobe_q <= '0;
    end else begin
      we_q     <= go;
      byp_q    <= byp;
      strobe_q <= strobe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ofs_q  <= '0;
      data_q <= '0;
    end else if (go) begin
      idx_q  <= idx;
      ofs_q  <= ofs;
      data_q <= data;
    end
  end

  assign we_o     = we_q;
  assign strobe_o = strobe_q;
  assign byp_o    = byp_q;
  assign idx_o    = idx_q;
  assign ofs_o    = ofs_q;
  assign data_o   = data_q;

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_q) && ((|strobe_q) == we_q));

  p_we_needs_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> byp_q);

  p_payload_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(idx_q) && $stable(ofs_q) && $stable(data_q)));

endmodule

// File: rtl/sprite_wr_steer.sv
module sprite_wr_steer
  import spr_steer_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 9,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PLANES = 2,
  parameter logic [SEG_W-1:0] SEG_LO_VAL = 16'hA000,
  parameter logic [SEG_W-1:0] SEG_HI_VAL = 16'hB000,
  localparam int unsigned IDX_W = ADDR_W - OFS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              mem_we,
  input  logic [SEG_W-1:0]  mem_seg,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic              spr_we,
  output logic [IDX_W-1:0]  spr_idx,
  output logic [OFS_W-1:0]  spr_ofs,
  output logic [PLANES-1:0] spr_plane_we,
  output logic [DATA_W-1:0] spr_data,
  output logic              gfx_bypass
);

  // Reset is asserted asynchronously and released on a clock edge.
  logic rst_meta;
  logic rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ctrl_t             ctrl;
  logic              in_win;
  logic              hit;
  logic [IDX_W-1:0]  idx_c;
  logic [OFS_W-1:0]  ofs_c;
  logic              go;
  logic              byp;

  spr_ctrl_reg #(
    .REG_W (REG_W)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync),
    .we    (reg_we),
    .wdata (reg_wdata),
    .ctrl  (ctrl),
    .rdata (reg_rdata)
  );

  spr_addr_map #(
    .SEG_W      (SEG_W),
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .SEG_LO_VAL (SEG_LO_VAL),
    .SEG_HI_VAL (SEG_HI_VAL)
  ) u_map (
    .ctrl   (ctrl),
    .seg    (mem_seg),
    .addr   (mem_addr),
    .in_win (in_win),
    .hit    (hit),
    .idx    (idx_c),
    .ofs    (ofs_c)
  );

  always_comb begin
    go  = mem_we && ctrl.en && hit;
    byp = mem_we && ctrl.en && in_win;
  end

  spr_out_stage #(
    .PLANES (PLANES),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .OFS_W  (OFS_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_sync),
    .go        (go),
    .byp       (byp),
    .plane_sel (ctrl.plane),
    .idx       (idx_c),
    .ofs       (ofs_c),
    .data      (mem_data),
    .we_o      (spr_we),
    .strobe_o  (spr_plane_we),
    .byp_o     (gfx_bypass),
    .idx_o     (spr_idx),
    .ofs_o     (spr_ofs),
    .data_o    (spr_data)
  );

  p_off_is_silent_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_we && !ctrl.en) |=> (!spr_we && !gfx_bypass));

  p_hi_swapped_drop_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_we && ctrl.swap && (mem_seg == SEG_HI_VAL)) |=> !spr_we);

  p_foreign_seg_r11: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_we && (mem_seg != SEG_LO_VAL) && (mem_seg != SEG_HI_VAL)) |=> (!spr_we && !gfx_bypass));

  p_lo_swapped_upper_r7: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_we && ctrl.en && ctrl.swap && (mem_seg == SEG_LO_VAL)) |=> (spr_we && spr_idx[IDX_W-1]));

  p_lo_plain_lower_r6: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_we && ctrl.en && !ctrl.swap && (mem_seg == SEG_LO_VAL)) |=> (spr_we && !spr_idx[IDX_W-1]));

endmodule

// File: tb/test_sprite_wr_steer.sv
`timescale 1ns/1ps
module test_sprite_wr_steer;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        mem_we;
  logic [15:0] mem_seg;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        spr_we;
  logic [8:0]  spr_idx;
  logic [8:0]  spr_ofs;
  logic [1:0]  spr_plane_we;
  logic [7:0]  spr_data;
  logic        gfx_bypass;

  int n_chk;
  int n_fail;
  bit done;

  sprite_wr_steer i_sprite_wr_steer (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .mem_we       (mem_we),
    .mem_seg      (mem_seg),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .spr_we       (spr_we),
    .spr_idx      (spr_idx),
    .spr_ofs      (spr_ofs),
    .spr_plane_we (spr_plane_we),
    .spr_data     (spr_data),
    .gfx_bypass   (gfx_bypass)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  // Presents one CPU write, then returns at the negedge after it was registered.
  task automatic cpu_wr(input logic [15:0] seg, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    mem_we   = 1'b1;
    mem_seg  = seg;
    mem_addr = a;
    mem_data = d;
    @(negedge clk);
    mem_we   = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", 32'(reg_rdata), 32'h0);
    chk("R1 spr_we", 32'(spr_we), 32'h0);
    chk("R1 strobe", 32'(spr_plane_we), 32'h0);
    chk("R1 bypass", 32'(gfx_bypass), 32'h0);
  endtask

  task automatic t_register;
    wr_ctrl(8'hFF);
    chk("R2 upper bits read 0", 32'(reg_rdata), 32'h0F);
    wr_ctrl(8'hA5);
    chk("R2 pattern A5", 32'(reg_rdata), 32'h05);
    wr_ctrl(8'h3A);
    chk("R2 pattern 3A", 32'(reg_rdata), 32'h0A);
    wr_ctrl(8'h00);
    chk("R2 cleared", 32'(reg_rdata), 32'h00);
  endtask

  task automatic t_disabled;
    wr_ctrl(8'h0E);
    cpu_wr(16'hA000, 16'h1234, 8'h5A);
    chk("R3 A seg spr_we", 32'(spr_we), 32'h0);
    chk("R3 A seg bypass", 32'(gfx_bypass), 32'h0);
    cpu_wr(16'hB000, 16'h0200, 8'h11);
    chk("R3 B seg spr_we", 32'(spr_we), 32'h0);
    chk("R3 B seg bypass", 32'(gfx_bypass), 32'h0);
  endtask

  task automatic t_map_all;
    for (int sw = 0; sw < 2; sw++) begin
      for (int pg = 0; pg < 2; pg++) begin
        for (int pl = 0; pl < 2; pl++) begin
          for (int hi = 0; hi < 2; hi++) begin
            logic [7:0]  cv;
            logic [15:0] a;
            logic [7:0]  d;
            logic        exp_we;
            int          base;
            cv = 8'(pg * 8 + pl * 4 + sw * 2 + 1);
            a  = 16'((sw * 37 + pg * 71 + pl * 13 + hi * 5 + 3) * 517);
            d  = 8'(8'hC3 ^ cv ^ 8'(hi));
            wr_ctrl(cv);
            if (hi == 0) begin
              exp_we = 1'b1;
              base   = sw * 256 + pg * 128;
            end else begin
              exp_we = (sw == 0);
              base   = 256 + pg * 128;
            end
            cpu_wr(hi ? 16'hB000 : 16'hA000, a, d);
            chk("R4 bypass", 32'(gfx_bypass), 32'h1);
            if (hi == 1 && sw == 1) begin
              chk("R9 swapped B drops", 32'(spr_we), 32'h0);
              chk("R5 no strobe", 32'(spr_plane_we), 32'h0);
            end else begin
              chk("R4 spr_we", 32'(spr_we), 32'(exp_we));
              if (hi == 0 && sw == 0)
                chk("R6 A index", 32'(spr_idx), 32'(base + int'(a[15:9])));
              else if (hi == 0)
                chk("R7 A swapped index", 32'(spr_idx), 32'(base + int'(a[15:9])));
              else
                chk("R8 B index", 32'(spr_idx), 32'(base + int'(a[15:9])));
              chk("R5 strobe", 32'(spr_plane_we), pl ? 32'h2 : 32'h1);
              chk("R10 offset", 32'(spr_ofs), 32'(a[8:0]));
              chk("R10 data", 32'(spr_data), 32'(d));
            end
          end
        end
      end
    end
  endtask

  task automatic t_edges;
    wr_ctrl(8'h09);
    cpu_wr(16'hA000, 16'hFFFF, 8'hFF);
    chk("R6 top of bank idx", 32'(spr_idx), 32'd255);
    chk("R10 top offset", 32'(spr_ofs), 32'h1FF);
    wr_ctrl(8'h03);
    cpu_wr(16'hA000, 16'h0000, 8'h00);
    chk("R7 bottom of upper idx", 32'(spr_idx), 32'd256);
    chk("R10 zero offset", 32'(spr_ofs), 32'h0);
  endtask

  task automatic t_foreign;
    wr_ctrl(8'h01);
    cpu_wr(16'hB800, 16'h0400, 8'h77);
    chk("R11 B800 spr_we", 32'(spr_we), 32'h0);
    chk("R11 B800 bypass", 32'(gfx_bypass), 32'h0);
    cpu_wr(16'hA001, 16'h0400, 8'h77);
    chk("R11 A001 spr_we", 32'(spr_we), 32'h0);
    chk("R11 A001 bypass", 32'(gfx_bypass), 32'h0);
  endtask

  task automatic t_same_cycle;
    wr_ctrl(8'h00);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_wdata = 8'h01;
    mem_we    = 1'b1;
    mem_seg   = 16'hA000;
    mem_addr  = 16'h0600;
    mem_data  = 8'h42;
    @(negedge clk);
    reg_we = 1'b0;
    mem_we = 1'b0;
    chk("R12 old value steers", 32'(spr_we), 32'h0);
    chk("R12 old value bypass", 32'(gfx_bypass), 32'h0);
    cpu_wr(16'hA000, 16'h0600, 8'h42);
    chk("R12 new value next", 32'(spr_we), 32'h1);
    chk("R12 new value idx", 32'(spr_idx), 32'd3);
    @(negedge clk);
    chk("R4 idle clears we", 32'(spr_we), 32'h0);
  endtask

  initial begin
    done      = 1'b0;
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_wdata = 8'h00;
    mem_we    = 1'b0;
    mem_seg   = 16'h0000;
    mem_addr  = 16'h0000;
    mem_data  = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_register;
    t_disabled;
    t_map_all;
    t_edges;
    t_foreign;
    t_same_cycle;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule